// File: doc/BRIEF.md
# MMU Control-Space Register Port

This block sits on the register-access path of a memory management unit. Each cycle it can take one request made of an address-space code, an offset into that space, 64-bit write data, a read/write strobe and a flag that says whether the requester is hyper-privileged. It decodes the request against the MMU control spaces. It holds two translation tag registers, one for the instruction side and one for the data side. It also holds a partition identifier and a file of eight scratchpad registers. Read data and the error flag come back combinationally in the cycle the request is presented. An error response always carries zero data and changes no state.

Loading a translation is indirect. Software first writes the virtual page and context into a tag register. It then writes the page-table entry into one of four insert spaces. The block forms an insert command from the stored tag, the current partition identifier and fields taken from the offset of that write. It presents the command on registered outputs for exactly one cycle. The translation buffer that consumes the command lies outside this block, and so does any real error logging.

Top module: `mmu_regport`

## Requirements
- R1: After a synchronous reset both tag registers, the partition register and all scratchpad registers read as zero, and `ins_valid` is low.
- R2: Space code 0x10 offset 0x30 is the instruction tag register and space code 0x11 offset 0x30 is the data tag register. They are independent 64-bit registers, and a read returns the stored value in the same cycle.
- R3: Space 0x11 offset 0x80 is the partition register. It keeps the low PART_W bits of the write data and reads back zero-extended.
- R4: Any other offset in space 0x10 or 0x11, and any space code not listed in these requirements, gives `rsp_err` with zero read data and leaves every register unchanged.
- R5: Spaces 0x16 and 0x17 both reach the same scratchpad file, and the register is selected by offset bits 5:3 (offset shifted right by three). Offset bits 2:0 are ignored.
- R6: A scratchpad access is rejected when the offset is above 0x38. It is also rejected when the offset lies in 0x20..0x2F and `req_hyper` is low. A rejected write does not modify the register.
- R7: A write to space 0x13 (instruction side) or 0x15 (data side) produces an insert in the next cycle. The insert has `ins_auto` = 0 and `ins_index` taken from offset bits 8:3.
- R8: A write to space 0x12 (instruction side) or 0x14 (data side) produces an insert with `ins_auto` = 1 and `ins_index` = 0. Such a write is rejected as an error, with no insert, when any offset bit other than 10 and 9 is set.
- R9: Every insert carries `ins_real` = offset bit 9, `ins_fmt` = offset bit 10 and `ins_pte` = the write data. It also carries `ins_side` (0 instruction, 1 data) and the matching tag register split into `ins_vpn` = bits 63:13 and `ins_ctx` = bits 12:0, together with the current partition value.
- R10: Space 0x18 (error status) reads as zero without error. Writes to 0x18 or to 0x19 (error enable) are accepted and have no effect. A read of 0x19 is an error.
- R11: A read of any of the four insert spaces is an error.
- R12: `ins_valid` is a single-cycle pulse that appears only after an accepted insert write. When no request is presented, `rsp_err` is low and `rsp_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_space | input | 8 | Address-space code |
| req_offset | input | 12 | Offset within the space |
| req_wdata | input | 64 | Write data |
| req_hyper | input | 1 | Requester is hyper-privileged |
| rsp_rdata | output | 64 | Read data, same cycle |
| rsp_err | output | 1 | Access error, same cycle |
| ins_valid | output | 1 | Insert command pulse |
| ins_side | output | 1 | 0 instruction side, 1 data side |
| ins_auto | output | 1 | Replacement slot chosen by the buffer |
| ins_index | output | 6 | Explicit entry index |
| ins_real | output | 1 | Real-address translation flag |
| ins_fmt | output | 1 | Page-table-entry format select |
| ins_vpn | output | 51 | Virtual page from tag register |
| ins_ctx | output | 13 | Context from tag register |
| ins_part | output | 8 | Partition identifier |
| ins_pte | output | 64 | Page-table entry |

## Verification
The hardest case to reach is an insert whose fields come from state written several requests earlier. Its tag comes from the tag register of the correct side, its partition from a separate earlier write, and its index, real flag and format from the offset of the insert write itself. The stimulus therefore loads distinct patterns into both tag registers and the partition register first. It then issues inserts on both sides with different offset bit combinations. Each insert is checked on the cycle after the write, and checked again one cycle later to confirm the pulse has dropped. A malformed data-in offset follows to confirm that no command appears.

// File: rtl/mmu_regport_pkg.sv
package mmu_regport_pkg;

    localparam int DATA_W  = 64;
    localparam int CTX_W   = 13;
    localparam int VPN_W   = DATA_W - CTX_W;
    localparam int IDX_W   = 6;
    localparam int OFS_W   = 12;
    localparam int SPACE_W = 8;

    localparam logic [SPACE_W-1:0] SPC_IMMU     = 8'h10;
    localparam logic [SPACE_W-1:0] SPC_DMMU     = 8'h11;
    localparam logic [SPACE_W-1:0] SPC_ITLB_IN  = 8'h12;
    localparam logic [SPACE_W-1:0] SPC_ITLB_ACC = 8'h13;
    localparam logic [SPACE_W-1:0] SPC_DTLB_IN  = 8'h14;
    localparam logic [SPACE_W-1:0] SPC_DTLB_ACC = 8'h15;
    localparam logic [SPACE_W-1:0] SPC_SCR      = 8'h16;
    localparam logic [SPACE_W-1:0] SPC_HSCR     = 8'h17;
    localparam logic [SPACE_W-1:0] SPC_ERR_STAT = 8'h18;
    localparam logic [SPACE_W-1:0] SPC_ERR_EN   = 8'h19;

    localparam logic [OFS_W-1:0] OFS_TAG     = 12'h030;
    localparam logic [OFS_W-1:0] OFS_PART    = 12'h080;
    localparam logic [OFS_W-1:0] OFS_HPR_LO  = 12'h020;
    localparam logic [OFS_W-1:0] OFS_HPR_HI  = 12'h02F;
    localparam logic [OFS_W-1:0] OFS_IN_MASK = 12'h600;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_ITAG,
        ACT_DTAG,
        ACT_PART,
        ACT_SCR,
        ACT_ZERO,
        ACT_INSERT
    } act_e;

    typedef struct packed {
        act_e             act;
        logic             err;
        logic [2:0]       scr_idx;
        logic             side;
        logic             autoi;
        logic [IDX_W-1:0] idx;
        logic             real_f;
        logic             fmt;
    } dec_t;

    function automatic logic ofs_in(input logic [OFS_W-1:0] o,
                                    input logic [OFS_W-1:0] lo,
                                    input logic [OFS_W-1:0] hi);
        return (o >= lo) && (o <= hi);
    endfunction

endpackage

// File: rtl/mmu_space_decode.sv
module mmu_space_decode
    import mmu_regport_pkg::*;
#(
    parameter int SCR_N = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [SPACE_W-1:0] req_space,
    input  logic [OFS_W-1:0]   req_offset,
    input  logic               req_hyper,
    output dec_t               dec
);
    localparam logic [OFS_W-1:0] SCR_LAST = OFS_W'((SCR_N - 1) * 8);

    always_comb begin
        dec     = '0;
        dec.act = ACT_NONE;
        if (req_valid) begin
            unique case (req_space)
                SPC_IMMU: begin
                    if (req_offset == OFS_TAG) dec.act = ACT_ITAG;
                    else                       dec.err = 1'b1;
                end
                SPC_DMMU: begin
                    if (req_offset == OFS_TAG)       dec.act = ACT_DTAG;
                    else if (req_offset == OFS_PART) dec.act = ACT_PART;
                    else                             dec.err = 1'b1;
                end
                SPC_SCR, SPC_HSCR: begin
                    if (req_offset > SCR_LAST)
                        dec.err = 1'b1;
                    else if (ofs_in(req_offset, OFS_HPR_LO, OFS_HPR_HI) && !req_hyper)
                        dec.err = 1'b1;
                    else begin
                        dec.act     = ACT_SCR;
                        dec.scr_idx = req_offset[5:3];
                    end
                end
                SPC_ERR_STAT: dec.act = ACT_ZERO;
                SPC_ERR_EN: begin
                    if (req_write) dec.act = ACT_ZERO;
                    else           dec.err = 1'b1;
                end
                SPC_ITLB_IN, SPC_DTLB_IN: begin
                    if (!req_write || ((req_offset & ~OFS_IN_MASK) != '0))
                        dec.err = 1'b1;
                    else begin
                        dec.act    = ACT_INSERT;
                        dec.autoi  = 1'b1;
                        dec.side   = (req_space == SPC_DTLB_IN);
                        dec.real_f = req_offset[9];
                        dec.fmt    = req_offset[10];
                    end
                end
                SPC_ITLB_ACC, SPC_DTLB_ACC: begin
                    if (!req_write)
                        dec.err = 1'b1;
                    else begin
                        dec.act    = ACT_INSERT;
                        dec.side   = (req_space == SPC_DTLB_ACC);
                        dec.idx    = req_offset[8:3];
                        dec.real_f = req_offset[9];
                        dec.fmt    = req_offset[10];
                    end
                end
                default: dec.err = 1'b1;
            endcase
        end
    end

    // R6: protected scratch window refused to ordinary requesters
    p_scr_hyper_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_hyper &&
         (req_space == SPC_SCR || req_space == SPC_HSCR) &&
         ofs_in(req_offset, OFS_HPR_LO, OFS_HPR_HI))
        |-> (dec.err && dec.act == ACT_NONE));

endmodule

// File: rtl/mmu_scratch_file.sv
module mmu_scratch_file
    import mmu_regport_pkg::*;
#(
    parameter int SCR_N = 8,
    localparam int SEL_W = $clog2(SCR_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] slot_q [SCR_N];

    for (genvar g = 0; g < SCR_N; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)                                   slot_q[g] <= '0;
            else if (we && sel == SEL_W'(g))           slot_q[g] <= wdata;
        end

        // R5: a slot only moves when it is the selected write target
        p_slot_hold_r5: assert property (@(posedge clk) disable iff (rst)
            !(we && sel == SEL_W'(g)) |=> $stable(slot_q[g]));
    end

    assign rdata = slot_q[sel];

endmodule

// File: rtl/mmu_insert_gen.sv
module mmu_insert_gen
    import mmu_regport_pkg::*;
#(
    parameter int PART_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  dec_t              dec,
    input  logic [DATA_W-1:0] itag,
    input  logic [DATA_W-1:0] dtag,
    input  logic [PART_W-1:0] part,
    input  logic [DATA_W-1:0] pte,
    output logic              ins_valid,
    output logic              ins_side,
    output logic              ins_auto,
    output logic [IDX_W-1:0]  ins_index,
    output logic              ins_real,
    output logic              ins_fmt,
    output logic [VPN_W-1:0]  ins_vpn,
    output logic [CTX_W-1:0]  ins_ctx,
    output logic [PART_W-1:0] ins_part,
    output logic [DATA_W-1:0] ins_pte
);
    logic [DATA_W-1:0] tag_sel;
    assign tag_sel = dec.side ? dtag : itag;

    always_ff @(posedge clk) begin
        if (rst) begin
            ins_valid <= 1'b0;
            ins_side  <= 1'b0;
            ins_auto  <= 1'b0;
            ins_index <= '0;
            ins_real  <= 1'b0;
            ins_fmt   <= 1'b0;
            ins_vpn   <= '0;
            ins_ctx   <= '0;
            ins_part  <= '0;
            ins_pte   <= '0;
        end else begin
            ins_valid <= fire;
            if (fire) begin
                ins_side  <= dec.side;
                ins_auto  <= dec.autoi;
                ins_index <= dec.idx;
                ins_real  <= dec.real_f;
                ins_fmt   <= dec.fmt;
                ins_vpn   <= tag_sel[DATA_W-1:CTX_W];
                ins_ctx   <= tag_sel[CTX_W-1:0];
                ins_part  <= part;
                ins_pte   <= pte;
            end
        end
    end

    // R8: automatic replacement never carries an explicit index
    p_auto_idx_r8: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && ins_auto) |-> (ins_index == '0));

    // R12: the command lasts one cycle unless another insert follows
    p_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && !fire) |=> !ins_valid);

endmodule

// File: rtl/mmu_regport.sv
module mmu_regport
    import mmu_regport_pkg::*;
#(
    parameter int SCR_N  = 8,
    parameter int PART_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [SPACE_W-1:0] req_space,
    input  logic [OFS_W-1:0]   req_offset,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic               req_hyper,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               rsp_err,
    output logic               ins_valid,
    output logic               ins_side,
    output logic               ins_auto,
    output logic [IDX_W-1:0]   ins_index,
    output logic               ins_real,
    output logic               ins_fmt,
    output logic [VPN_W-1:0]   ins_vpn,
    output logic [CTX_W-1:0]   ins_ctx,
    output logic [PART_W-1:0]  ins_part,
    output logic [DATA_W-1:0]  ins_pte
);
    localparam int SEL_W = $clog2(SCR_N);

    dec_t              dec;
    logic              wr_ok;
    logic [DATA_W-1:0] itag_q, dtag_q, scr_rd;
    logic [PART_W-1:0] part_q;

    mmu_space_decode #(.SCR_N(SCR_N)) u_dec (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_space  (req_space),
        .req_offset (req_offset),
        .req_hyper  (req_hyper),
        .dec        (dec)
    );

    assign wr_ok = req_valid && req_write && !dec.err;

    always_ff @(posedge clk) begin
        if (rst) begin
            itag_q <= '0;
            dtag_q <= '0;
            part_q <= '0;
        end else if (wr_ok) begin
            if (dec.act == ACT_ITAG) itag_q <= req_wdata;
            if (dec.act == ACT_DTAG) dtag_q <= req_wdata;
            if (dec.act == ACT_PART) part_q <= req_wdata[PART_W-1:0];
        end
    end

    mmu_scratch_file #(.SCR_N(SCR_N)) u_scr (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_ok && dec.act == ACT_SCR),
        .sel   (dec.scr_idx[SEL_W-1:0]),
        .wdata (req_wdata),
        .rdata (scr_rd)
    );

    mmu_insert_gen #(.PART_W(PART_W)) u_ins (
        .clk       (clk),
        .rst       (rst),
        .fire      (wr_ok && dec.act == ACT_INSERT),
        .dec       (dec),
        .itag      (itag_q),
        .dtag      (dtag_q),
        .part      (part_q),
        .pte       (req_wdata),
        .ins_valid (ins_valid),
        .ins_side  (ins_side),
        .ins_auto  (ins_auto),
        .ins_index (ins_index),
        .ins_real  (ins_real),
        .ins_fmt   (ins_fmt),
        .ins_vpn   (ins_vpn),
        .ins_ctx   (ins_ctx),
        .ins_part  (ins_part),
        .ins_pte   (ins_pte)
    );

    always_comb begin
        rsp_rdata = '0;
        if (req_valid && !req_write && !dec.err) begin
            unique case (dec.act)
                ACT_ITAG: rsp_rdata = itag_q;
                ACT_DTAG: rsp_rdata = dtag_q;
                ACT_PART: rsp_rdata[PART_W-1:0] = part_q;
                ACT_SCR:  rsp_rdata = scr_rd;
                default:  rsp_rdata = '0;
            endcase
        end
    end
    assign rsp_err = dec.err;

    // R4: a refused access leaves the control registers alone
    p_err_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && rsp_err) |=> ($stable(itag_q) && $stable(dtag_q) && $stable(part_q)));

    // R12: an error response carries zero data
    p_err_zero_r12: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_rdata == '0));

    // R12: quiet outputs with no request
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!rsp_err && rsp_rdata == '0));

    // R7: an insert only follows an accepted write
    p_ins_after_write_r7: assert property (@(posedge clk) disable iff (rst)
        ins_valid |-> $past(req_valid && req_write && !rsp_err));

endmodule

// File: tb/mmu_regport_tb.sv
module mmu_regport_tb;
    import mmu_regport_pkg::*;

    localparam int PART_W = 8;
    localparam logic [63:0] D1 = 64'hDEAD_BEEF_1234_5A6B;
    localparam logic [63:0] I1 = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] S3 = 64'h3333_0000_0000_0003;
    localparam logic [63:0] S5 = 64'h5555_0000_0000_0005;
    localparam logic [63:0] PA = 64'hFFFF_FFFF_FFFF_FFA5;

    typedef struct packed {
        logic        wr;
        logic [7:0]  sp;
        logic [11:0] off;
        logic [63:0] wd;
        logic        hy;
        logic        eerr;
        logic [63:0] erd;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VT [NV] = '{
        '{1'b0, SPC_IMMU,     12'h030, 64'h0, 1'b0, 1'b0, 64'h0,  4'd1},  // R1
        '{1'b0, SPC_SCR,      12'h000, 64'h0, 1'b0, 1'b0, 64'h0,  4'd1},  // R1
        '{1'b1, SPC_DMMU,     12'h030, D1,    1'b0, 1'b0, 64'h0,  4'd2},  // R2
        '{1'b1, SPC_IMMU,     12'h030, I1,    1'b0, 1'b0, 64'h0,  4'd2},  // R2
        '{1'b0, SPC_DMMU,     12'h030, 64'h0, 1'b0, 1'b0, D1,     4'd2},  // R2
        '{1'b0, SPC_IMMU,     12'h030, 64'h0, 1'b0, 1'b0, I1,     4'd2},  // R2
        '{1'b1, SPC_DMMU,     12'h080, PA,    1'b0, 1'b0, 64'h0,  4'd3},  // R3
        '{1'b0, SPC_DMMU,     12'h080, 64'h0, 1'b0, 1'b0, 64'hA5, 4'd3},  // R3
        '{1'b0, SPC_IMMU,     12'h080, 64'h0, 1'b0, 1'b1, 64'h0,  4'd4},  // R4
        '{1'b1, SPC_DMMU,     12'h038, 64'h1, 1'b0, 1'b1, 64'h0,  4'd4},  // R4
        '{1'b1, SPC_IMMU,     12'h031, 64'h2, 1'b0, 1'b1, 64'h0,  4'd4},  // R4
        '{1'b0, SPC_DMMU,     12'h030, 64'h0, 1'b0, 1'b0, D1,     4'd4},  // R4
        '{1'b0, SPC_IMMU,     12'h030, 64'h0, 1'b0, 1'b0, I1,     4'd4},  // R4
        '{1'b0, 8'h3F,        12'h030, 64'h0, 1'b0, 1'b1, 64'h0,  4'd4},  // R4
        '{1'b1, SPC_SCR,      12'h018, S3,    1'b0, 1'b0, 64'h0,  4'd5},  // R5
        '{1'b0, SPC_HSCR,     12'h018, 64'h0, 1'b0, 1'b0, S3,     4'd5},  // R5
        '{1'b0, SPC_SCR,      12'h01F, 64'h0, 1'b0, 1'b0, S3,     4'd5},  // R5
        '{1'b1, SPC_SCR,      12'h020, S5,    1'b0, 1'b1, 64'h0,  4'd6},  // R6
        '{1'b0, SPC_SCR,      12'h020, 64'h0, 1'b1, 1'b0, 64'h0,  4'd6},  // R6
        '{1'b1, SPC_HSCR,     12'h028, S5,    1'b1, 1'b0, 64'h0,  4'd6},  // R6
        '{1'b0, SPC_SCR,      12'h028, 64'h0, 1'b1, 1'b0, S5,     4'd6},  // R6
        '{1'b0, SPC_SCR,      12'h028, 64'h0, 1'b0, 1'b1, 64'h0,  4'd6},  // R6
        '{1'b0, SPC_SCR,      12'h040, 64'h0, 1'b1, 1'b1, 64'h0,  4'd6},  // R6
        '{1'b1, SPC_SCR,      12'h03A, S5,    1'b1, 1'b1, 64'h0,  4'd6},  // R6
        '{1'b0, SPC_ERR_STAT, 12'h000, 64'h0, 1'b0, 1'b0, 64'h0,  4'd10}, // R10
        '{1'b1, SPC_ERR_STAT, 12'h000, S5,    1'b0, 1'b0, 64'h0,  4'd10}, // R10
        '{1'b1, SPC_ERR_EN,   12'h000, S5,    1'b0, 1'b0, 64'h0,  4'd10}, // R10
        '{1'b0, SPC_ERR_EN,   12'h000, 64'h0, 1'b0, 1'b1, 64'h0,  4'd10}, // R10
        '{1'b0, SPC_DTLB_IN,  12'h000, 64'h0, 1'b0, 1'b1, 64'h0,  4'd11}, // R11
        '{1'b0, SPC_ITLB_ACC, 12'h008, 64'h0, 1'b0, 1'b1, 64'h0,  4'd11}, // R11
        '{1'b0, SPC_SCR,      12'h038, 64'h0, 1'b0, 1'b0, 64'h0,  4'd5}   // R5
    };

    logic               clk = 1'b0;
    logic               rst;
    logic               req_valid, req_write, req_hyper;
    logic [SPACE_W-1:0] req_space;
    logic [OFS_W-1:0]   req_offset;
    logic [DATA_W-1:0]  req_wdata;
    logic [DATA_W-1:0]  rsp_rdata;
    logic               rsp_err;
    logic               ins_valid, ins_side, ins_auto, ins_real, ins_fmt;
    logic [IDX_W-1:0]   ins_index;
    logic [VPN_W-1:0]   ins_vpn;
    logic [CTX_W-1:0]   ins_ctx;
    logic [PART_W-1:0]  ins_part;
    logic [DATA_W-1:0]  ins_pte;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    mmu_regport #(.SCR_N(8), .PART_W(PART_W)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_space(req_space),
        .req_offset(req_offset), .req_wdata(req_wdata), .req_hyper(req_hyper),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .ins_valid(ins_valid), .ins_side(ins_side), .ins_auto(ins_auto),
        .ins_index(ins_index), .ins_real(ins_real), .ins_fmt(ins_fmt),
        .ins_vpn(ins_vpn), .ins_ctx(ins_ctx), .ins_part(ins_part), .ins_pte(ins_pte)
    );

    task automatic check(input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic [7:0] sp, input logic [11:0] off,
                         input logic [63:0] wd, input logic hy);
        @(negedge clk);
        req_valid  = 1'b1;
        req_write  = wr;
        req_space  = sp;
        req_offset = off;
        req_wdata  = wd;
        req_hyper  = hy;
        #1;
    endtask

    task automatic idle_step();
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        #1;
    endtask

    task automatic check_insert(input string rq, input logic side, input logic au,
                                input logic [5:0] idx, input logic rl, input logic fm,
                                input logic [63:0] tag, input logic [63:0] pte);
        check(rq, "ins_valid", 64'(ins_valid), 64'd1);
        check(rq, "ins_side",  64'(ins_side),  64'(side));
        check(rq, "ins_auto",  64'(ins_auto),  64'(au));
        check(rq, "ins_index", 64'(ins_index), 64'(idx));
        check(rq, "ins_real",  64'(ins_real),  64'(rl));
        check(rq, "ins_fmt",   64'(ins_fmt),   64'(fm));
        check(rq, "ins_vpn",   64'(ins_vpn),   64'(tag[63:13]));
        check(rq, "ins_ctx",   64'(ins_ctx),   64'(tag[12:0]));
        check(rq, "ins_part",  64'(ins_part),  64'hA5);
        check(rq, "ins_pte",   ins_pte,        pte);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int stray;
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_hyper = 1'b0;
        req_space = '0; req_offset = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state of the insert channel and idle outputs (R12)
        check("R1", "ins_valid after reset", 64'(ins_valid), 64'd0);
        check("R12", "idle rsp_err", 64'(rsp_err), 64'd0);

        // Table walk; R12: no insert may appear during it
        stray = 0;
        for (int i = 0; i < NV; i++) begin
            drive(VT[i].wr, VT[i].sp, VT[i].off, VT[i].wd, VT[i].hy);
            if (ins_valid) stray++;
            check($sformatf("R%0d", VT[i].rq), $sformatf("vec %0d err", i),
                  64'(rsp_err), 64'(VT[i].eerr));
            check($sformatf("R%0d", VT[i].rq), $sformatf("vec %0d rdata", i),
                  rsp_rdata, VT[i].erd);
        end
        idle_step();
        if (ins_valid) stray++;
        check("R12", "stray inserts in table", 64'(stray), 64'd0);
        check("R12", "idle rdata", rsp_rdata, 64'd0);

        // R7 / R9: data-side explicit index 5, real=1, fmt=0
        drive(1'b1, SPC_DTLB_ACC, 12'h228, 64'hAAAA_0000_1111_2222, 1'b0);
        check("R7", "access write err", 64'(rsp_err), 64'd0);
        idle_step();
        check_insert("R7", 1'b1, 1'b0, 6'd5, 1'b1, 1'b0, D1, 64'hAAAA_0000_1111_2222);
        idle_step();
        check("R12", "pulse dropped", 64'(ins_valid), 64'd0);

        // R8 / R9: instruction-side auto, fmt=1, real=0
        drive(1'b1, SPC_ITLB_IN, 12'h400, 64'hBBBB_0000_3333_4444, 1'b0);
        check("R8", "data-in write err", 64'(rsp_err), 64'd0);
        idle_step();
        check_insert("R9", 1'b0, 1'b1, 6'd0, 1'b0, 1'b1, I1, 64'hBBBB_0000_3333_4444);

        // R7: instruction-side explicit index 63 with both flags
        drive(1'b1, SPC_ITLB_ACC, 12'h7F8, 64'hCCCC_0000_5555_6666, 1'b0);
        idle_step();
        check_insert("R7", 1'b0, 1'b0, 6'd63, 1'b1, 1'b1, I1, 64'hCCCC_0000_5555_6666);

        // R8: malformed data-in offset is rejected and no insert follows
        drive(1'b1, SPC_DTLB_IN, 12'h408, 64'h1, 1'b0);
        check("R8", "bad data-in err", 64'(rsp_err), 64'd1);
        idle_step();
        check("R8", "no insert after bad data-in", 64'(ins_valid), 64'd0);

        // R9: tag update is picked up by a later data-side auto insert
        drive(1'b1, SPC_DMMU, 12'h030, I1, 1'b0);
        drive(1'b1, SPC_DTLB_IN, 12'h200, 64'h77, 1'b0);
        idle_step();
        check_insert("R9", 1'b1, 1'b1, 6'd0, 1'b1, 1'b0, I1, 64'h77);

        // R1: reset clears registers again
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        drive(1'b0, SPC_DMMU, 12'h080, 64'h0, 1'b0);
        check("R1", "partition after reset", rsp_rdata, 64'd0);
        drive(1'b0, SPC_HSCR, 12'h028, 64'h0, 1'b1);
        check("R1", "scratch after reset", rsp_rdata, 64'd0);
        idle_step();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule